// File: doc/BRIEF.md
# Temporary operand register file

A two-operand coprocessor pipeline often needs more source values than its instruction can carry. This block is a small side register file that holds those extra operands. Move commands load it ahead of the accelerator instruction, and the accelerator's stages then read the entries they need through independent combinational read ports.

There are three kinds of move. A single move writes one value into an entry that the command names. A reset move writes two values into entries 0 and 1 and sets an internal write pointer to 2. A paired move writes two values at the pointer and at the pointer plus one, then advances the pointer by two. With these, a run of operands can be loaded without each move naming its address. If a paired move would run past the last entry, its writes are dropped and a sticky overflow flag is raised.

Top module: `tmp_opnd_rf`

## Requirements
- R1: When `cmd_valid` is 1 and `cmd_op` is 2'b01 (single move), `cmd_a` is written into entry `cmd_idx`. The write pointer is unchanged.
- R2: When `cmd_op` is 2'b10 (reset move), `cmd_a` is written into entry 0 and `cmd_b` into entry 1, and the write pointer becomes 2.
- R3: When `cmd_op` is 2'b11 (paired move) and the pointer is at most DEPTH-2, `cmd_a` is written into entry ptr and `cmd_b` into entry ptr+1, and the pointer advances by 2.
- R4: Each of the NRD read ports returns, combinationally, the entry selected by its own address field. Port g uses bits [g*IW +: IW] of `rd_addr` and bits [g*WIDTH +: WIDTH] of `rd_data`.
- R5: A read of an entry that is being written in the same cycle returns the old value. The new value is visible from the cycle after the clock edge.
- R6: A paired move issued while the pointer is greater than DEPTH-2 writes no entry, leaves the pointer unchanged, and sets `ovf` to 1 from the next cycle.
- R7: Once set, `ovf` stays at 1 until reset. A reset move does not clear it. Single and reset moves keep working while `ovf` is 1.
- R8: A synchronous active-high `rst` clears every entry to 0, sets the pointer to 0 and clears `ovf`. A paired move after reset therefore fills entries 0 and 1.
- R9: A command with `cmd_valid` at 0, or with `cmd_op` at 2'b00, changes no entry, no pointer and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Move command present |
| cmd_op | input | 2 | 00 none, 01 single, 10 reset move, 11 paired move |
| cmd_idx | input | IW | Target entry for a single move |
| cmd_a | input | WIDTH | First operand of a move |
| cmd_b | input | WIDTH | Second operand of a move |
| rd_addr | input | NRD*IW | Packed read addresses, one field per port |
| rd_data | output | NRD*WIDTH | Packed read data, one field per port |
| ovf | output | 1 | Sticky pointer overflow flag |

## Verification
The hardest state to reach is overflow. The pointer cannot be set directly, so getting there takes a reset move followed by enough paired moves to bring the pointer to DEPTH. Only then is one more paired move issued. Its dropped writes are then shown at the read ports by checking every entry against the model. A following reset move and paired move show that the flag stays set and that the pointer is usable again. The same-cycle read case is checked by sampling the read port between the command being driven and the clock edge that commits it.

// File: rtl/tmp_opnd_rf.sv
module tmp_opnd_rf #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  parameter int NRD   = 2,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [IW-1:0]        cmd_idx,
  input  logic [WIDTH-1:0]     cmd_a,
  input  logic [WIDTH-1:0]     cmd_b,
  input  logic [NRD*IW-1:0]    rd_addr,
  output logic [NRD*WIDTH-1:0] rd_data,
  output logic                 ovf
);
  localparam int PW = IW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    ptr;

  wire do_single = cmd_valid && (cmd_op == 2'b01);
  wire do_rmov   = cmd_valid && (cmd_op == 2'b10);
  wire do_pair   = cmd_valid && (cmd_op == 2'b11);
  wire pair_fits = ptr <= PW'(DEPTH - 2);
  wire [IW-1:0] wa0 = ptr[IW-1:0];
  wire [IW-1:0] wa1 = ptr[IW-1:0] + IW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      ptr <= '0;
      ovf <= 1'b0;
    end else begin
      if (do_single) mem[cmd_idx] <= cmd_a;
      if (do_rmov) begin
        mem[0] <= cmd_a;
        mem[1] <= cmd_b;
        ptr    <= PW'(2);
      end
      if (do_pair) begin
        if (pair_fits) begin
          mem[wa0] <= cmd_a;
          mem[wa1] <= cmd_b;
          ptr      <= ptr + PW'(2);
        end else begin
          ovf <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g*WIDTH +: WIDTH] = mem[rd_addr[g*IW +: IW]];
  end
endmodule

// File: rtl/tmp_opnd_rf_chk.sv
module tmp_opnd_rf_chk #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  parameter int IW    = $clog2(DEPTH),
  parameter int PW    = IW + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [IW-1:0]    cmd_idx,
  input logic [WIDTH-1:0] cmd_a,
  input logic [WIDTH-1:0] cmd_b,
  input logic [IW-1:0]    rd_addr0,
  input logic [WIDTH-1:0] rd_data0,
  input logic             ovf,
  input logic [PW-1:0]    ptr
);
  wire single = cmd_valid && cmd_op == 2'b01;
  wire rmov   = cmd_valid && cmd_op == 2'b10;
  wire pair   = cmd_valid && cmd_op == 2'b11;
  wire idle   = !cmd_valid || cmd_op == 2'b00;

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    single && cmd_idx == rd_addr0 |=> (!$stable(rd_addr0) || rd_data0 == $past(cmd_a))); // R1
  AST_RMOV_PTR: assert property (@(posedge clk) disable iff (rst)
    rmov |=> ptr == PW'(2)); // R2
  AST_RMOV_HIGH: assert property (@(posedge clk) disable iff (rst)
    rmov && rd_addr0 == IW'(1) |=> (!$stable(rd_addr0) || rd_data0 == $past(cmd_b))); // R2
  AST_PAIR_STEP: assert property (@(posedge clk) disable iff (rst)
    pair && ptr <= PW'(DEPTH - 2) |=> ptr == $past(ptr) + PW'(2)); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    pair && ptr > PW'(DEPTH - 2) |=> ovf && $stable(ptr)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R7
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> !ovf && ptr == '0 && rd_data0 == '0); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    idle |=> $stable(ptr) && (!$stable(rd_addr0) || $stable(rd_data0))); // R9
endmodule

bind tmp_opnd_rf tmp_opnd_rf_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
  .cmd_a(cmd_a), .cmd_b(cmd_b), .rd_addr0(rd_addr[IW-1:0]),
  .rd_data0(rd_data[WIDTH-1:0]), .ovf(ovf), .ptr(ptr)
);

// File: tb/sim_tmp_opnd_rf.sv
module sim_tmp_opnd_rf;
  localparam int DEPTH = 8, WIDTH = 32, NRD = 2, IW = 3;

  logic clk = 0, rst = 1, cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [IW-1:0] cmd_idx = 0;
  logic [WIDTH-1:0] cmd_a = 0, cmd_b = 0;
  logic [NRD*IW-1:0] rd_addr = 0;
  logic [NRD*WIDTH-1:0] rd_data;
  logic ovf;

  tmp_opnd_rf #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NRD(NRD)) u0 (.*);

  always #2 clk = ~clk;

  int nchk = 0, nbad = 0;
  logic [WIDTH-1:0] em [DEPTH];
  int eptr;
  logic eovf;

  task automatic check(string tag, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd2(int a0, int a1, output logic [WIDTH-1:0] d0, output logic [WIDTH-1:0] d1);
    rd_addr[0 +: IW] = IW'(a0);
    rd_addr[IW +: IW] = IW'(a1);
    #0.5;
    d0 = rd_data[0 +: WIDTH];
    d1 = rd_data[WIDTH +: WIDTH];
  endtask

  task automatic check_all(string tag);
    logic [WIDTH-1:0] d0, d1;
    for (int i = 0; i < DEPTH; i++) begin
      rd2(i, DEPTH - 1 - i, d0, d1);
      check({tag, " port0"}, d0, em[i]);
      check({tag, " port1 R4"}, d1, em[DEPTH - 1 - i]);
    end
    check({tag, " ovf"}, {31'b0, ovf}, {31'b0, eovf});
  endtask

  task automatic issue(logic v, logic [1:0] op, int idx, logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_idx = IW'(idx); cmd_a = a; cmd_b = b;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
    if (v) begin
      case (op)
        2'b01: em[idx] = a;
        2'b10: begin em[0] = a; em[1] = b; eptr = 2; end
        2'b11: if (eptr <= DEPTH - 2) begin em[eptr] = a; em[eptr + 1] = b; eptr += 2; end
               else eovf = 1;
        default: ;
      endcase
    end
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    for (int i = 0; i < DEPTH; i++) em[i] = '0;
    eptr = 0; eovf = 0;
    check_all("R8 reset");
  endtask

  task automatic t_single;
    issue(1, 2'b01, 3, 32'hA0A0_0003, 32'hDEAD_0000);
    issue(1, 2'b01, 7, 32'hA0A0_0007, 32'hDEAD_0001);
    check_all("R1 single");
    issue(1, 2'b11, 0, 32'h1111_0000, 32'h1111_0001);
    check_all("R1 pointer untouched by single, R8 paired from 0");
  endtask

  task automatic t_rmov_pair;
    issue(1, 2'b10, 5, 32'hB000_0000, 32'hB000_0001);
    check_all("R2 reset move");
    issue(1, 2'b11, 0, 32'hC000_0002, 32'hC000_0003);
    issue(1, 2'b11, 0, 32'hC000_0004, 32'hC000_0005);
    issue(1, 2'b11, 0, 32'hC000_0006, 32'hC000_0007);
    check_all("R3 paired fill");
  endtask

  task automatic t_overflow;
    issue(1, 2'b11, 0, 32'hEEEE_EEEE, 32'hFFFF_FFFF);
    check_all("R6 overflow drop");
    issue(1, 2'b01, 4, 32'h4444_4444, 32'h0);
    issue(1, 2'b10, 0, 32'h5000_0000, 32'h5000_0001);
    issue(1, 2'b11, 0, 32'h5000_0002, 32'h5000_0003);
    check_all("R7 sticky ovf, moves still work");
  endtask

  task automatic t_idle;
    issue(1, 2'b00, 6, 32'h9999_9999, 32'h9999_9998);
    issue(0, 2'b11, 6, 32'h9999_9997, 32'h9999_9996);
    issue(0, 2'b01, 6, 32'h9999_9995, 32'h9999_9994);
    check_all("R9 idle");
  endtask

  task automatic t_same_cycle;
    logic [WIDTH-1:0] d0, d1;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'b01; cmd_idx = 3'd5; cmd_a = 32'h5A5A_5A5A;
    rd2(5, 5, d0, d1);
    check("R5 same-cycle read old port0", d0, em[5]);
    check("R5 same-cycle read old port1", d1, em[5]);
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
    em[5] = 32'h5A5A_5A5A;
    rd2(5, 5, d0, d1);
    check("R5 new value next cycle", d0, 32'h5A5A_5A5A);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_single;
        t_rmov_pair;
        t_overflow;
        t_idle;
        t_same_cycle;
        t_reset;
        issue(1, 2'b11, 0, 32'h0F0F_0000, 32'h0F0F_0001);
        check_all("R8 paired after reset");
      end
      begin
        #(200000 * 4);
        nchk++; nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule